// File: doc/BRIEF.md
# Synchronous SRAM Access Control Logic

This block turns the registered control pins of a single-cycle-access synchronous SRAM into the internal strobes that drive the array. It decodes three chip enables, two address strobes and a set of write inputs. From these it produces registered per-byte write enables, a matching per-bit write mask for a RAM written bit by bit, a one-cycle read-valid pulse, and the enable for the data-output drivers.

There are two address strobes, and they follow different rules. The processor strobe always opens a read. Its write inputs are ignored in that first cycle. At the next clock edge it looks at the write inputs again and turns the access into a write if they are active. The controller strobe decides in its own cycle. With the write inputs inactive it opens a read; with them active it performs the write at once. A global write overrides the per-lane write enable and lane selects and writes every lane. A snooze input puts the block in standby, so that nothing can start and nothing is written.

The memory array and the burst address counter belong to neighbouring blocks. Read data is expected in the cycle after the clock edge that accepts the read.

Top module: `sram_ctl_top`

## Requirements
- R1: An access can start only at a clock edge where `chip_en0_n` is 0, `chip_en1` is 1 and `chip_en2_n` is 0. Any other combination starts nothing.
- R2: When `chip_en0_n` is 1, a low `cpu_strobe_n` has no effect. `rd_valid` and `lane_we` stay 0 in the next cycle.
- R3: A selected edge with `cpu_strobe_n` low (this strobe wins if both strobes are low) makes `rd_valid` 1 for exactly the following cycle. The write inputs at that edge are ignored.
- R4: A selected edge with only `ctl_strobe_n` low and no write lane active makes `rd_valid` 1 for the following cycle.
- R5: A selected edge with only `ctl_strobe_n` low and at least one write lane active makes `lane_we` equal the lane mask for the following cycle, with `rd_valid` 0.
- R6: On the edge after a processor-strobe start, active write inputs make `lane_we` equal the lane mask for one cycle. This applies unless that edge is itself a new processor-strobe start, which then opens a read and ignores the write inputs.
- R7: `all_wr_n` = 0 gives a lane mask of all ones, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R8: With `all_wr_n` = 1 and `lane_wr_en_n` = 0, lane i is written when `lane_sel_n[i]` = 0. Lane i covers bits 8i+7..8i, and `bit_we[8i+7:8i]` copies `lane_we[i]`.
- R9: With `all_wr_n` = 1 and `lane_wr_en_n` = 1, the lane mask is 0, and the cycle is a read or no access.
- R10: `dq_oe` is 1 only while `out_en_n` = 0, `snooze` = 0, `rd_valid` = 1 and no lane is being written. It follows `out_en_n` with no clock delay.
- R11: At an edge where `snooze` is 1, all other inputs are ignored. No start or pending write is carried on, and `rd_valid` and `lane_we` are 0 in the next cycle.
- R12: Reset is synchronous and active high. After a reset edge, `rd_valid`, `lane_we` and `bit_we` are 0, and no pending processor access remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| snooze | input | 1 | Standby request, active high |
| chip_en0_n | input | 1 | Chip enable 0, active low; also gates the processor strobe |
| chip_en1 | input | 1 | Chip enable 1, active high |
| chip_en2_n | input | 1 | Chip enable 2, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Per-lane write enable, active low |
| lane_sel_n | input | 4 | Lane selects, active low, bit i for byte lane i |
| out_en_n | input | 1 | Output enable pin, active low, asynchronous |
| rd_valid | output | 1 | Read data phase, one cycle after a read start |
| lane_we | output | 4 | Registered per-byte write enables |
| bit_we | output | 32 | Per-bit write mask expanded from `lane_we` |
| dq_oe | output | 1 | Data output driver enable |

## Verification
The only stored state is the pending flag left by a processor-strobe start. If that flag were wrong, the error would show one edge later. Either a write that should follow a processor start would not appear on `lane_we`, or a write would appear after a controller read, a deselect or a snooze. A wrong lane decode shows on `lane_we` and `bit_we` in the cycle right after the edge that accepted the access. Because `dq_oe` is combinational from `out_en_n`, a fault there appears within the same cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // Strobe decode result for one clock edge
  typedef struct packed {
    logic sel;      // chip enables all asserted and not in standby
    logic p_start;  // processor strobe accepted
    logic c_start;  // controller strobe accepted (processor strobe idle)
  } start_t;

  // Kind of access decided at an edge
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

endpackage

// File: rtl/sram_sel_decode.sv
module sram_sel_decode
  import sram_ctl_pkg::*;
(
  input  logic   snooze,
  input  logic   chip_en0_n,
  input  logic   chip_en1,
  input  logic   chip_en2_n,
  input  logic   cpu_strobe_n,
  input  logic   ctl_strobe_n,
  output start_t st
);

  logic sel;

  // Standby masks every other input
  assign sel = ~snooze & ~chip_en0_n & chip_en1 & ~chip_en2_n;

  always_comb begin
    st.sel     = sel;
    // Processor strobe depends on chip_en0_n through sel and has priority
    st.p_start = sel & ~cpu_strobe_n;
    st.c_start = sel & cpu_strobe_n & ~ctl_strobe_n;
  end

endmodule

// File: rtl/sram_wr_mask.sv
module sram_wr_mask #(
  parameter int NUM_LANES = 4
) (
  input  logic                 all_wr_n,
  input  logic                 lane_wr_en_n,
  input  logic [NUM_LANES-1:0] lane_sel_n,
  output logic [NUM_LANES-1:0] lane_mask,
  output logic                 any_lane
);

  // Global write overrides the lane enable and selects
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_mask[i] = ~all_wr_n | (~lane_wr_en_n & ~lane_sel_n[i]);
  end

  assign any_lane = |lane_mask;

endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
  import sram_ctl_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 snooze,
  input  start_t               st,
  input  logic [NUM_LANES-1:0] lane_mask,
  input  logic                 any_lane,
  output logic                 rd_valid,
  output logic [NUM_LANES-1:0] lane_we
);

  logic pend_q;
  acc_e acc;

  // Decide the access kind at this edge
  always_comb begin
    acc = ACC_NONE;
    if (st.p_start)
      acc = ACC_READ;                       // write inputs ignored here
    else if (st.c_start)
      acc = any_lane ? ACC_WRITE : ACC_READ;
    else if (pend_q && any_lane && !snooze)
      acc = ACC_WRITE;                      // follow-up of a processor start
  end

  always_ff @(posedge clk) begin
    if (rst || snooze) begin
      rd_valid <= 1'b0;
      lane_we  <= '0;
      pend_q   <= 1'b0;
    end else begin
      rd_valid <= (acc == ACC_READ);
      lane_we  <= (acc == ACC_WRITE) ? lane_mask : '0;
      pend_q   <= st.p_start;
    end
  end

endmodule

// File: rtl/sram_bit_expand.sv
module sram_bit_expand #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 8,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic [NUM_LANES-1:0] lane_we,
  output logic [DATA_W-1:0]    bit_we
);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign bit_we[i*LANE_W +: LANE_W] = {LANE_W{lane_we[i]}};
  end

endmodule

// File: rtl/sram_ctl_top.sv
module sram_ctl_top
  import sram_ctl_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 8,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 snooze,
  input  logic                 chip_en0_n,
  input  logic                 chip_en1,
  input  logic                 chip_en2_n,
  input  logic                 cpu_strobe_n,
  input  logic                 ctl_strobe_n,
  input  logic                 all_wr_n,
  input  logic                 lane_wr_en_n,
  input  logic [NUM_LANES-1:0] lane_sel_n,
  input  logic                 out_en_n,
  output logic                 rd_valid,
  output logic [NUM_LANES-1:0] lane_we,
  output logic [DATA_W-1:0]    bit_we,
  output logic                 dq_oe
);

  start_t               st;
  logic [NUM_LANES-1:0] lane_mask;
  logic                 any_lane;

  sram_sel_decode u_sel (
    .snooze       (snooze),
    .chip_en0_n   (chip_en0_n),
    .chip_en1     (chip_en1),
    .chip_en2_n   (chip_en2_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .st           (st)
  );

  sram_wr_mask #(.NUM_LANES(NUM_LANES)) u_mask (
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .lane_mask    (lane_mask),
    .any_lane     (any_lane)
  );

  sram_cycle_ctl #(.NUM_LANES(NUM_LANES)) u_cyc (
    .clk       (clk),
    .rst       (rst),
    .snooze    (snooze),
    .st        (st),
    .lane_mask (lane_mask),
    .any_lane  (any_lane),
    .rd_valid  (rd_valid),
    .lane_we   (lane_we)
  );

  sram_bit_expand #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_bits (
    .lane_we (lane_we),
    .bit_we  (bit_we)
  );

  // Output pin enable is asynchronous; drivers go high impedance during writes
  assign dq_oe = ~out_en_n & ~snooze & rd_valid & ~(|lane_we);

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 snooze,
  input logic                 chip_en0_n,
  input logic                 chip_en1,
  input logic                 chip_en2_n,
  input logic                 cpu_strobe_n,
  input logic                 ctl_strobe_n,
  input logic                 all_wr_n,
  input logic                 rd_valid,
  input logic [NUM_LANES-1:0] lane_we
);

  logic sel_pins;
  assign sel_pins = ~chip_en0_n & chip_en1 & ~chip_en2_n;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rd_valid && lane_we == '0)); // R12

  AST_DESEL_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !sel_pins |=> !rd_valid); // R1

  AST_CS0_BLOCKS_CPU: assert property (@(posedge clk) disable iff (rst)
    (chip_en0_n && !cpu_strobe_n) |=> !rd_valid); // R2

  AST_CPU_READS: assert property (@(posedge clk) disable iff (rst)
    (sel_pins && !snooze && !cpu_strobe_n) |=> (rd_valid && lane_we == '0)); // R3

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (sel_pins && !snooze && cpu_strobe_n && !ctl_strobe_n && !all_wr_n)
      |=> (lane_we == {NUM_LANES{1'b1}} && !rd_valid)); // R7

  AST_SNOOZE_IDLE: assert property (@(posedge clk) disable iff (rst)
    snooze |=> (!rd_valid && lane_we == '0)); // R11

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && cpu_strobe_n && ctl_strobe_n) |=> !rd_valid); // R3

endmodule

bind sram_ctl_top sram_ctl_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .snooze       (snooze),
  .chip_en0_n   (chip_en0_n),
  .chip_en1     (chip_en1),
  .chip_en2_n   (chip_en2_n),
  .cpu_strobe_n (cpu_strobe_n),
  .ctl_strobe_n (ctl_strobe_n),
  .all_wr_n     (all_wr_n),
  .rd_valid     (rd_valid),
  .lane_we      (lane_we)
);

// File: tb/sim_sram_ctl_top.sv
module sim_sram_ctl_top;

  localparam int NL = 4;
  localparam int LW = 8;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, snooze, ce0_n, ce1, ce2_n, p_n, c_n, gw_n, bwe_n, oe_n;
  logic [NL-1:0] bsel_n;
  logic          rd_valid, dq_oe;
  logic [NL-1:0] lane_we;
  logic [DW-1:0] bit_we;

  sram_ctl_top #(.NUM_LANES(NL), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .snooze(snooze),
    .chip_en0_n(ce0_n), .chip_en1(ce1), .chip_en2_n(ce2_n),
    .cpu_strobe_n(p_n), .ctl_strobe_n(c_n),
    .all_wr_n(gw_n), .lane_wr_en_n(bwe_n), .lane_sel_n(bsel_n),
    .out_en_n(oe_n),
    .rd_valid(rd_valid), .lane_we(lane_we), .bit_we(bit_we), .dq_oe(dq_oe)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state from the requirements
  logic          e_rd;
  logic [NL-1:0] e_we;
  logic          e_pend;

  function automatic logic [NL-1:0] lanes_of(logic gw, logic bwe, logic [NL-1:0] bs);
    logic [NL-1:0] m;
    if (!gw) m = '1;                 // R7
    else if (!bwe) m = ~bs;          // R8
    else m = '0;                     // R9
    return m;
  endfunction

  function automatic logic [DW-1:0] bits_of(logic [NL-1:0] l);
    logic [DW-1:0] b;
    for (int i = 0; i < NL; i++) b[i*LW +: LW] = {LW{l[i]}};
    return b;
  endfunction

  task automatic model_edge();
    logic sel, ps, cs;
    logic [NL-1:0] m;
    sel = !ce0_n && ce1 && !ce2_n;
    ps  = sel && !p_n;
    cs  = sel && p_n && !c_n;
    m   = lanes_of(gw_n, bwe_n, bsel_n);
    if (rst || snooze) begin
      e_rd = 0; e_we = '0; e_pend = 0;
    end else begin
      e_rd = ps || (cs && m == '0);
      e_we = ((cs || (e_pend && !ps)) && m != '0) ? m : '0;
      e_pend = ps;
    end
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " rd_valid"}, DW'(rd_valid), DW'(e_rd));
    chk({tag, " lane_we"}, DW'(lane_we), DW'(e_we));
    chk({tag, " bit_we R8"}, bit_we, bits_of(e_we));
    chk({tag, " dq_oe R10"}, DW'(dq_oe),
        DW'(!oe_n && !snooze && e_rd && e_we == '0));
  endtask

  task automatic idle();
    rst = 0; snooze = 0; ce0_n = 0; ce1 = 1; ce2_n = 0;
    p_n = 1; c_n = 1; gw_n = 1; bwe_n = 1; bsel_n = '1; oe_n = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R12 act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    e_rd = 0; e_we = '0; e_pend = 0;
    idle(); rst = 1; gw_n = 0; p_n = 0;
    step("R12 reset");
    step("R12 reset held");
    @(negedge clk); idle(); step("idle");

    // R3: processor start ignores write inputs
    p_n = 0; gw_n = 0; step("R3 cpu start");
    idle(); step("R6 no follow-up write");
    // R6 + R8: follow-up write with lane selects
    p_n = 0; step("R6 cpu start");
    idle(); bwe_n = 0; bsel_n = 4'b1010; step("R6 follow-up write");
    idle(); step("R6 write done");
    // R6: back-to-back processor starts
    p_n = 0; step("R6 cpu start a");
    gw_n = 0; step("R6 second start ignores writes");
    idle(); step("R6 tail");
    // R2
    ce0_n = 1; p_n = 0; gw_n = 0; step("R2 cs0 high");
    idle(); step("R2 after");
    // R1
    ce1 = 0; c_n = 0; step("R1 ce1 low");
    idle(); ce2_n = 1; c_n = 0; step("R1 ce2 high");
    idle(); p_n = 0; c_n = 0; ce1 = 0; step("R1 both strobes deselected");
    // R4 + R9
    idle(); c_n = 0; bwe_n = 0; bsel_n = '1; step("R4 ctl read, R9 no lanes");
    idle(); c_n = 0; step("R4 ctl read");
    // R5 + R7
    idle(); c_n = 0; gw_n = 0; step("R5 R7 global write");
    idle(); c_n = 0; gw_n = 0; bwe_n = 0; bsel_n = 4'b1110; step("R7 override");
    // R8 each lane
    for (int i = 0; i < NL; i++) begin
      idle(); c_n = 0; bwe_n = 0; bsel_n = ~(NL'(1) << i); step("R8 single lane");
    end
    // R10
    idle(); p_n = 0; oe_n = 1; step("R10 oe high");
    idle(); oe_n = 1; step("R10 idle");
    idle(); p_n = 0; step("R10 read drives");
    // R11
    idle(); snooze = 1; p_n = 0; step("R11 snooze start");
    idle(); p_n = 0; step("R11 cpu start");
    idle(); snooze = 1; gw_n = 0; step("R11 snooze drops pending");
    idle(); gw_n = 0; step("R11 no late write");
    // R12 mid-access
    idle(); p_n = 0; step("R12 start");
    idle(); rst = 1; gw_n = 0; step("R12 reset clears pending");
    idle(); gw_n = 0; step("R12 no write after reset");

    for (int n = 0; n < 3000; n++) begin
      rst    = ($urandom % 100) < 2;
      snooze = ($urandom % 100) < 5;
      ce0_n  = ($urandom % 100) < 15;
      ce1    = ($urandom % 100) >= 10;
      ce2_n  = ($urandom % 100) < 10;
      p_n    = ($urandom % 100) >= 35;
      c_n    = ($urandom % 100) >= 40;
      gw_n   = ($urandom % 100) >= 15;
      bwe_n  = ($urandom % 100) >= 45;
      bsel_n = NL'($urandom);
      oe_n   = ($urandom % 100) < 30;
      step("random R3 R5 R6 R7 R8 R10 R11");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule